// File: doc/BRIEF.md
# Dual-Bank Shared-Bus Enable Arbiter

This block sits at the front of a memory device in which an SRAM bank and a flash bank share one set of address lines, write data, write enable and output enable. Each bank has its own active-low enable. On every clock the block samples the shared bus. It decides which bank the cycle belongs to and drives that bank's port. It also returns read data to the bus together with a drive-enable for the bus's three-state buffer, and it raises a standby flag when no bank is selected.

Flash writes are only passed on as single-cycle pulses. A pulse is produced when a write strobe has stayed low for enough clock samples to pass a glitch filter. The pulse carries the address seen at the start of the strobe and the data seen at its end. Write-inhibit conditions cancel a strobe. The flash command and status logic behind the flash port is outside this block. The SRAM path never waits on the flash path, so software can run SRAM accesses while the flash is busy in the background.

The bank decoder is a state machine with six states. Each state is entered on the clock edge that follows a bus sample:
- `BK_STANDBY`: both enables are high.
- `BK_SEL_IDLE`: a bank is selected but no access qualifies. This covers output enable and write enable both high, a flash select with both strobes low, and an SRAM select outside the SRAM range.
- `BK_SRAM_RD`, `BK_SRAM_WR`: SRAM read and SRAM write.
- `BK_FLASH_RD`, `BK_FLASH_WR`: flash read and flash write strobe.

The strobe filter is a second state machine with four states:
- `FW_IDLE` goes to `FW_COUNT` on the first qualifying low sample. If the threshold is one sample, it goes straight to `FW_ARMED`.
- `FW_COUNT` goes to `FW_ARMED` once the threshold is reached. It returns to `FW_IDLE` if the strobe ends early.
- `FW_ARMED` goes to `FW_PULSE` when the strobe is released. It goes back to `FW_IDLE` if output enable falls while the strobe is still low.
- `FW_PULSE` lasts one cycle and then behaves as `FW_IDLE`.

Top module: `dualbank_arbiter`

## Requirements
- R1: With both bank enables high, `standby` is 1 and there is no SRAM access, no flash read and no bus drive. Reset leaves the block in this state.
- R2: When both bank enables are low, the flash bank takes the cycle. A read goes to the flash port, and no SRAM access or SRAM write occurs.
- R3: An SRAM read needs the SRAM enable low, output enable low, write enable high and an in-range address. It asserts `sram_access`, drives the bus, and returns `sram_rdata` on `bus_rdata`.
- R4: `bus_drive` is 0 in every cycle whose bus sample had output enable high.
- R5: An SRAM write needs the SRAM enable and write enable low, and output enable may be at either level. It asserts `sram_write` with `sram_addr` equal to the low SRAM_AW address bits and `sram_wdata` equal to the bus data, and the bus is not driven.
- R6: The SRAM occupies only the addresses whose bits SRAM_AW and above are zero. An SRAM-enabled access at any other address produces no SRAM access or write and no bus drive.
- R7: A flash read needs the flash enable low, output enable low and write enable high. It asserts `flash_read` with `flash_rd_addr` equal to the bus address, drives the bus, and returns `flash_rdata`.
- R8: A flash write pulse never results from samples with the flash enable high, with write enable high, or with output enable low. A strobe during which output enable falls while write enable is still low is cancelled.
- R9: A flash write strobe that stays low for fewer than GLITCH_MIN consecutive samples produces no pulse.
- R10: An accepted strobe gives exactly one `flash_wr_pulse` of one cycle. `flash_wr_addr` is the address of the strobe's first low sample and `flash_wr_data` is the data of its last low sample.
- R11: An SRAM read or write sampled in the same cycle as a flash strobe release, or while the flash write is in progress, is serviced with its normal latency and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Shared address |
| bus_wdata | input | DATA_W | Shared write data |
| sel_sram_n | input | 1 | SRAM bank enable, active low |
| sel_flash_n | input | 1 | Flash bank enable, active low |
| wr_n | input | 1 | Shared write enable, active low |
| rd_n | input | 1 | Shared output enable, active low |
| bus_rdata | output | DATA_W | Read data towards the bus |
| bus_drive | output | 1 | 1 while `bus_rdata` is to be driven, 0 for high impedance |
| standby | output | 1 | No bank selected |
| sram_access | output | 1 | SRAM port access (read or write) |
| sram_write | output | 1 | SRAM port write |
| sram_addr | output | SRAM_AW | SRAM port address |
| sram_wdata | output | DATA_W | SRAM port write data |
| sram_rdata | input | DATA_W | SRAM port read data |
| flash_read | output | 1 | Flash port read |
| flash_rd_addr | output | ADDR_W | Flash port read address |
| flash_rdata | input | DATA_W | Flash port read data |
| flash_wr_pulse | output | 1 | One-cycle accepted flash write |
| flash_wr_addr | output | ADDR_W | Address captured at strobe start |
| flash_wr_data | output | DATA_W | Data captured at strobe end |

## Verification
Every result is due on the second rising edge after the bus is driven. The first edge captures the bus sample. The second edge moves either the decoder or the filter into its new state, and the outputs decode directly from that state. Bank routing, bus drive, read data and standby are due two edges after the sample that causes them. A flash write pulse is due two edges after the cycle in which the strobe is released. The driver enqueues each expectation tagged with that due cycle. A monitor on the falling edge pops only the items whose cycle has arrived, so the outputs are compared while they are stable. For rejected or cancelled strobes, no-pulse items are enqueued for each cycle around the release.

// File: rtl/dba_pkg.sv
package dba_pkg;

    typedef enum logic [2:0] {
        BK_STANDBY,
        BK_SEL_IDLE,
        BK_SRAM_RD,
        BK_SRAM_WR,
        BK_FLASH_RD,
        BK_FLASH_WR
    } bank_state_t;

    typedef enum logic [1:0] {
        FW_IDLE,
        FW_COUNT,
        FW_ARMED,
        FW_PULSE
    } fw_state_t;

endpackage

// File: rtl/dba_sampler.sv
module dba_sampler #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              sel_sram_n,
    input  logic              sel_flash_n,
    input  logic              wr_n,
    input  logic              rd_n,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    output logic              s_ssel_n,
    output logic              s_fsel_n,
    output logic              s_we_n,
    output logic              s_oe_n
);

    // One register stage: every later decision works on this sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_addr   <= '0;
            s_wdata  <= '0;
            s_ssel_n <= 1'b1;
            s_fsel_n <= 1'b1;
            s_we_n   <= 1'b1;
            s_oe_n   <= 1'b1;
        end else begin
            s_addr   <= bus_addr;
            s_wdata  <= bus_wdata;
            s_ssel_n <= sel_sram_n;
            s_fsel_n <= sel_flash_n;
            s_we_n   <= wr_n;
            s_oe_n   <= rd_n;
        end
    end

endmodule

// File: rtl/dba_bank_fsm.sv
module dba_bank_fsm
    import dba_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int SRAM_AW = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  s_addr,
    input  logic [DATA_W-1:0]  s_wdata,
    input  logic               s_ssel_n,
    input  logic               s_fsel_n,
    input  logic               s_we_n,
    input  logic               s_oe_n,
    input  logic [DATA_W-1:0]  sram_rdata,
    input  logic [DATA_W-1:0]  flash_rdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_drive,
    output logic               standby,
    output logic               sram_access,
    output logic               sram_write,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [DATA_W-1:0]  sram_wdata,
    output logic               flash_read,
    output logic [ADDR_W-1:0]  flash_rd_addr
);

    localparam int HI_W = ADDR_W - SRAM_AW;

    bank_state_t state, nxt;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_wdata;
    logic              in_range;

    assign in_range = (s_addr[ADDR_W-1:SRAM_AW] == HI_W'(0));

    // Next-state decode: the flash enable is tested first, so it dominates.
    always_comb begin
        nxt = BK_SEL_IDLE;
        if (!s_fsel_n) begin
            if (!s_oe_n && s_we_n)
                nxt = BK_FLASH_RD;
            else if (!s_we_n && s_oe_n)
                nxt = BK_FLASH_WR;
            else
                nxt = BK_SEL_IDLE;
        end else if (!s_ssel_n) begin
            if (!in_range)
                nxt = BK_SEL_IDLE;
            else if (!s_we_n)
                nxt = BK_SRAM_WR;
            else if (!s_oe_n)
                nxt = BK_SRAM_RD;
            else
                nxt = BK_SEL_IDLE;
        end else begin
            nxt = BK_STANDBY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= BK_STANDBY;
            p_addr  <= '0;
            p_wdata <= '0;
        end else begin
            state   <= nxt;
            p_addr  <= s_addr;
            p_wdata <= s_wdata;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        bus_rdata   = '0;
        bus_drive   = 1'b0;
        standby     = 1'b0;
        sram_access = 1'b0;
        sram_write  = 1'b0;
        flash_read  = 1'b0;
        unique case (state)
            BK_STANDBY:  standby = 1'b1;
            BK_SEL_IDLE: ;
            BK_SRAM_RD: begin
                sram_access = 1'b1;
                bus_drive   = 1'b1;
                bus_rdata   = sram_rdata;
            end
            BK_SRAM_WR: begin
                sram_access = 1'b1;
                sram_write  = 1'b1;
            end
            BK_FLASH_RD: begin
                flash_read = 1'b1;
                bus_drive  = 1'b1;
                bus_rdata  = flash_rdata;
            end
            BK_FLASH_WR: ;
            default: ;
        endcase
    end

    assign sram_addr     = p_addr[SRAM_AW-1:0];
    assign sram_wdata    = p_wdata;
    assign flash_rd_addr = p_addr;

    AST_STANDBY_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_fsel_n) && $past(s_ssel_n)) |-> (standby && !bus_drive)); // R1
    AST_FLASH_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(s_fsel_n) && !$past(s_ssel_n)) |-> (!sram_access && !sram_write)); // R2
    AST_OE_HIGH_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_oe_n) |-> !bus_drive); // R4
    AST_SRAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_addr[ADDR_W-1:SRAM_AW]) != HI_W'(0)) |-> !sram_access); // R6
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_access, flash_read, standby})); // R2

endmodule

// File: rtl/dba_wr_filter.sv
module dba_wr_filter
    import dba_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int GLITCH_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              s_fsel_n,
    input  logic              s_we_n,
    input  logic              s_oe_n,
    output logic              flash_wr_pulse,
    output logic [ADDR_W-1:0] flash_wr_addr,
    output logic [DATA_W-1:0] flash_wr_data
);

    localparam int CNT_W = $clog2(GLITCH_MIN + 1);
    localparam logic [CNT_W-1:0] THRESH = CNT_W'(GLITCH_MIN);

    fw_state_t         state, nxt;
    logic [CNT_W-1:0]  cnt, cnt_inc;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              act, inh, start;

    // Qualified strobe sample, and the inhibit case (output enable low).
    assign act     = !s_fsel_n && !s_we_n &&  s_oe_n;
    assign inh     = !s_fsel_n && !s_we_n && !s_oe_n;
    assign cnt_inc = cnt + CNT_W'(1);
    assign start   = ((state == FW_IDLE) || (state == FW_PULSE)) && act;

    always_comb begin
        nxt = FW_IDLE;
        unique case (state)
            FW_IDLE, FW_PULSE: begin
                if (act)
                    nxt = (GLITCH_MIN <= 1) ? FW_ARMED : FW_COUNT;
                else
                    nxt = FW_IDLE;
            end
            FW_COUNT: begin
                if (act)
                    nxt = (cnt_inc >= THRESH) ? FW_ARMED : FW_COUNT;
                else
                    nxt = FW_IDLE;
            end
            FW_ARMED: begin
                if (act)
                    nxt = FW_ARMED;
                else if (inh)
                    nxt = FW_IDLE;
                else
                    nxt = FW_PULSE;
            end
            default: nxt = FW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FW_IDLE;
            cnt      <= '0;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            state <= nxt;
            if (start) begin
                cnt      <= CNT_W'(1);
                lat_addr <= s_addr;
                lat_data <= s_wdata;
            end else if (act && (state == FW_COUNT)) begin
                cnt      <= cnt_inc;
                lat_data <= s_wdata;
            end else if (act && (state == FW_ARMED)) begin
                lat_data <= s_wdata;
            end
        end
    end

    always_comb begin
        flash_wr_pulse = (state == FW_PULSE);
        flash_wr_addr  = lat_addr;
        flash_wr_data  = lat_data;
    end

    AST_ARMED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FW_ARMED) |-> (cnt >= THRESH)); // R9
    AST_PULSE_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FW_PULSE) |-> ($past(state) == FW_ARMED)); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flash_wr_pulse |=> !flash_wr_pulse); // R10
    AST_INHIBIT_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FW_ARMED && inh) |=> (state == FW_IDLE)); // R8

endmodule

// File: rtl/dualbank_arbiter.sv
module dualbank_arbiter #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int SRAM_AW    = 17,
    parameter int GLITCH_MIN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               sel_sram_n,
    input  logic               sel_flash_n,
    input  logic               wr_n,
    input  logic               rd_n,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_drive,
    output logic               standby,
    output logic               sram_access,
    output logic               sram_write,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [DATA_W-1:0]  sram_wdata,
    input  logic [DATA_W-1:0]  sram_rdata,
    output logic               flash_read,
    output logic [ADDR_W-1:0]  flash_rd_addr,
    input  logic [DATA_W-1:0]  flash_rdata,
    output logic               flash_wr_pulse,
    output logic [ADDR_W-1:0]  flash_wr_addr,
    output logic [DATA_W-1:0]  flash_wr_data
);

    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_wdata;
    logic              s_ssel_n, s_fsel_n, s_we_n, s_oe_n;

    dba_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .sel_sram_n (sel_sram_n),
        .sel_flash_n(sel_flash_n),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .s_addr     (s_addr),
        .s_wdata    (s_wdata),
        .s_ssel_n   (s_ssel_n),
        .s_fsel_n   (s_fsel_n),
        .s_we_n     (s_we_n),
        .s_oe_n     (s_oe_n)
    );

    dba_bank_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRAM_AW(SRAM_AW)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_addr       (s_addr),
        .s_wdata      (s_wdata),
        .s_ssel_n     (s_ssel_n),
        .s_fsel_n     (s_fsel_n),
        .s_we_n       (s_we_n),
        .s_oe_n       (s_oe_n),
        .sram_rdata   (sram_rdata),
        .flash_rdata  (flash_rdata),
        .bus_rdata    (bus_rdata),
        .bus_drive    (bus_drive),
        .standby      (standby),
        .sram_access  (sram_access),
        .sram_write   (sram_write),
        .sram_addr    (sram_addr),
        .sram_wdata   (sram_wdata),
        .flash_read   (flash_read),
        .flash_rd_addr(flash_rd_addr)
    );

    dba_wr_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_MIN(GLITCH_MIN)) u_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .s_addr        (s_addr),
        .s_wdata       (s_wdata),
        .s_fsel_n      (s_fsel_n),
        .s_we_n        (s_we_n),
        .s_oe_n        (s_oe_n),
        .flash_wr_pulse(flash_wr_pulse),
        .flash_wr_addr (flash_wr_addr),
        .flash_wr_data (flash_wr_data)
    );

    AST_SRAM_WHILE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_wr_pulse && !$past(s_ssel_n) && $past(s_fsel_n) && !$past(s_oe_n)
         && $past(s_we_n) && ($past(s_addr) < ADDR_W'(1) << SRAM_AW)) |-> (sram_access && bus_drive)); // R11

endmodule

// File: tb/tb_dualbank_arbiter.sv
module tb_dualbank_arbiter;

    localparam int AW = 19;
    localparam int DW = 8;
    localparam int SAW = 17;

    localparam int K_STBY = 0, K_RD = 1, K_NODRV = 2, K_SWR = 3, K_NOSRAM = 4,
                   K_PULSE = 5, K_NOPULSE = 6, K_FRD = 7;

    typedef struct {
        int          due;
        int          kind;
        string       tag;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic sel_sram_n = 1'b1, sel_flash_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [DW-1:0] bus_rdata, sram_wdata, sram_rdata, flash_rdata, flash_wr_data;
    logic bus_drive, standby, sram_access, sram_write, flash_read, flash_wr_pulse;
    logic [SAW-1:0] sram_addr;
    logic [AW-1:0] flash_rd_addr, flash_wr_addr;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;
    item_t q[$];
    logic [7:0] smem [256];

    always #4 clk = ~clk;   // 125 MHz

    dualbank_arbiter dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .sel_sram_n(sel_sram_n), .sel_flash_n(sel_flash_n), .wr_n(wr_n), .rd_n(rd_n),
        .bus_rdata(bus_rdata), .bus_drive(bus_drive), .standby(standby),
        .sram_access(sram_access), .sram_write(sram_write), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .flash_read(flash_read),
        .flash_rd_addr(flash_rd_addr), .flash_rdata(flash_rdata),
        .flash_wr_pulse(flash_wr_pulse), .flash_wr_addr(flash_wr_addr),
        .flash_wr_data(flash_wr_data)
    );

    // Port models: small SRAM, flash data derived from address.
    assign sram_rdata  = smem[sram_addr[7:0]];
    assign flash_rdata = flash_rd_addr[7:0] ^ 8'h5A;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) smem[i] <= 8'(i * 3 + 1);
        end else if (sram_write) begin
            smem[sram_addr[7:0]] <= sram_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drv(input logic fs, input logic ss, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        #1;
        sel_flash_n = fs; sel_sram_n = ss; wr_n = we; rd_n = oe;
        bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(1, 1, 1, 1, '0, '0);
    endtask

    task automatic exp_at(input int off, input int k, input string tag,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
        item_t it;
        int pos;
        it.due = cyc + off; it.kind = k; it.tag = tag; it.a = a; it.d = d;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].due > it.due) begin pos = i; break; end
        end
        q.insert(pos, it);
    endtask

    // Monitor: compare due items away from the active edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.due < cyc) begin
                chk(0, it.tag, "missed item", 32'(cyc), 32'(it.due));
            end else begin
                case (it.kind)
                    K_STBY: begin
                        chk(standby == 1'b1, it.tag, "standby", 32'(standby), 1);
                        chk(!(bus_drive || sram_access || flash_read), it.tag, "quiet",
                            32'({bus_drive, sram_access, flash_read}), 0);
                    end
                    K_RD: begin
                        chk(bus_drive == 1'b1, it.tag, "bus_drive", 32'(bus_drive), 1);
                        chk(bus_rdata == it.d, it.tag, "bus_rdata", 32'(bus_rdata), 32'(it.d));
                    end
                    K_NODRV: chk(bus_drive == 1'b0, it.tag, "bus_drive", 32'(bus_drive), 0);
                    K_SWR: begin
                        chk(sram_write && sram_access, it.tag, "sram_write",
                            32'({sram_access, sram_write}), 3);
                        chk(sram_addr == it.a[SAW-1:0] && sram_wdata == it.d, it.tag,
                            "sram addr/data", {sram_addr[15:0], 8'h0, sram_wdata},
                            {it.a[15:0], 8'h0, it.d});
                    end
                    K_NOSRAM: chk(!sram_access && !sram_write, it.tag, "sram idle",
                                  32'({sram_access, sram_write}), 0);
                    K_PULSE: begin
                        chk(flash_wr_pulse == 1'b1, it.tag, "flash_wr_pulse",
                            32'(flash_wr_pulse), 1);
                        chk(flash_wr_addr == it.a && flash_wr_data == it.d, it.tag,
                            "flash wr addr/data", {5'h0, flash_wr_addr, flash_wr_data},
                            {5'h0, it.a, it.d});
                    end
                    K_NOPULSE: chk(flash_wr_pulse == 1'b0, it.tag, "flash_wr_pulse",
                                   32'(flash_wr_pulse), 0);
                    K_FRD: begin
                        chk(flash_read && bus_drive && bus_rdata == it.d, it.tag,
                            "flash read data", {22'h0, flash_read, bus_drive, bus_rdata},
                            {22'h0, 2'b11, it.d});
                        chk(flash_rd_addr == it.a, it.tag, "flash_rd_addr",
                            32'(flash_rd_addr), 32'(it.a));
                    end
                    default: chk(0, it.tag, "bad kind", 32'(it.kind), 0);
                endcase
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung actual=%0d expected=<5000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(standby == 1'b1 && bus_drive == 1'b0, "R1", "reset state",
            32'({standby, bus_drive}), 32'h2);
        rst_n = 1'b1;
        idle(3);

        // R1: standby
        drv(1, 1, 1, 0, 19'h00012, 0);
        exp_at(2, K_STBY, "R1", 0, 0);
        idle(3);

        // R5: SRAM write, output enable high then low
        drv(1, 0, 0, 1, 19'h00012, 8'hC3);
        exp_at(2, K_SWR, "R5", 19'h00012, 8'hC3);
        drv(1, 0, 0, 0, 19'h00034, 8'h5E);
        exp_at(2, K_SWR, "R5", 19'h00034, 8'h5E);
        exp_at(2, K_NODRV, "R5", 0, 0);
        idle(3);

        // R3: SRAM reads (written and untouched location)
        drv(1, 0, 1, 0, 19'h00012, 0);
        exp_at(2, K_RD, "R3", 0, 8'hC3);
        drv(1, 0, 1, 0, 19'h00007, 0);
        exp_at(2, K_RD, "R3", 0, 8'h16);
        idle(3);

        // R4: output enable high means no drive
        drv(1, 0, 1, 1, 19'h00012, 0);
        exp_at(2, K_NODRV, "R4", 0, 0);
        drv(0, 1, 1, 1, 19'h40012, 0);
        exp_at(2, K_NODRV, "R4", 0, 0);
        idle(3);

        // R6: SRAM enable above the SRAM range
        drv(1, 0, 1, 0, 19'h20012, 0);
        exp_at(2, K_NODRV, "R6", 0, 0);
        exp_at(2, K_NOSRAM, "R6", 0, 0);
        drv(1, 0, 0, 1, 19'h20034, 8'h00);
        exp_at(2, K_NOSRAM, "R6", 0, 0);
        idle(3);
        drv(1, 0, 1, 0, 19'h00034, 0);
        exp_at(2, K_RD, "R6", 0, 8'h5E);
        idle(3);

        // R7: flash read
        drv(0, 1, 1, 0, 19'h4ABCD, 0);
        exp_at(2, K_FRD, "R7", 19'h4ABCD, 8'hCD ^ 8'h5A);
        idle(3);

        // R2: both enables low
        drv(0, 0, 1, 0, 19'h00012, 0);
        exp_at(2, K_FRD, "R2", 19'h00012, 8'h12 ^ 8'h5A);
        exp_at(2, K_NOSRAM, "R2", 0, 0);
        for (int i = 0; i < 3; i++) begin
            drv(0, 0, 0, 1, 19'h00012, 8'h99);
            exp_at(2, K_NOSRAM, "R2", 0, 0);
        end
        drv(1, 1, 1, 1, 0, 0);
        exp_at(2, K_PULSE, "R2", 19'h00012, 8'h99);
        idle(3);
        drv(1, 0, 1, 0, 19'h00012, 0);
        exp_at(2, K_RD, "R2", 0, 8'hC3);
        idle(3);

        // R10: accepted strobe, address from first sample, data from last
        drv(0, 1, 0, 1, 19'h41230, 8'h11);
        drv(0, 1, 0, 1, 19'h41230, 8'h22);
        drv(0, 1, 0, 1, 19'h47777, 8'h33);
        drv(1, 1, 1, 1, 0, 0);
        exp_at(1, K_NOPULSE, "R10", 0, 0);
        exp_at(2, K_PULSE, "R10", 19'h41230, 8'h33);
        exp_at(3, K_NOPULSE, "R10", 0, 0);
        exp_at(4, K_NOPULSE, "R10", 0, 0);
        idle(4);

        // R9: short strobes (2 samples, then 1 sample)
        drv(0, 1, 0, 1, 19'h40100, 8'hA1);
        drv(0, 1, 0, 1, 19'h40100, 8'hA2);
        drv(1, 1, 1, 1, 0, 0);
        for (int i = 1; i <= 4; i++) exp_at(i, K_NOPULSE, "R9", 0, 0);
        idle(4);
        drv(0, 1, 0, 1, 19'h40200, 8'hB1);
        drv(1, 1, 1, 1, 0, 0);
        for (int i = 1; i <= 4; i++) exp_at(i, K_NOPULSE, "R9", 0, 0);
        idle(4);

        // R8: output enable falls during the strobe
        for (int i = 0; i < 3; i++) drv(0, 1, 0, 1, 19'h40300, 8'hC1);
        drv(0, 1, 0, 0, 19'h40300, 8'hC2);
        exp_at(2, K_NODRV, "R8", 0, 0);
        drv(1, 1, 1, 1, 0, 0);
        for (int i = 1; i <= 4; i++) exp_at(i, K_NOPULSE, "R8", 0, 0);
        idle(4);
        // R8: output enable low for the whole strobe
        for (int i = 0; i < 4; i++) drv(0, 1, 0, 0, 19'h40400, 8'hD1);
        drv(1, 1, 1, 1, 0, 0);
        for (int i = 1; i <= 4; i++) exp_at(i, K_NOPULSE, "R8", 0, 0);
        idle(4);
        // R8: write enable low with the flash enable high
        for (int i = 0; i < 4; i++) drv(1, 1, 0, 1, 19'h40500, 8'hE1);
        drv(1, 1, 1, 1, 0, 0);
        for (int i = 1; i <= 4; i++) exp_at(i, K_NOPULSE, "R8", 0, 0);
        idle(4);

        // R11: SRAM read in the release cycle, then SRAM write during flash work
        for (int i = 0; i < 3; i++) drv(0, 1, 0, 1, 19'h46000, 8'h77);
        drv(1, 0, 1, 0, 19'h00012, 0);
        exp_at(2, K_PULSE, "R11", 19'h46000, 8'h77);
        exp_at(2, K_RD, "R11", 0, 8'hC3);
        drv(1, 0, 0, 1, 19'h00056, 8'hA7);
        exp_at(2, K_SWR, "R11", 19'h00056, 8'hA7);
        idle(3);
        drv(1, 0, 1, 0, 19'h00056, 0);
        exp_at(2, K_RD, "R11", 0, 8'hA7);
        idle(5);

        chk(q.size() == 0, "R1", "scoreboard drained", 32'(q.size()), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule